// File: doc/BRIEF.md
# Multi-Port Parallel I/O Controller

This block moves bytes between a processor core and external devices over one 8-bit data bus. Eight logical ports share that bus. A 3-bit select output names the port that the current transfer addresses. The core side writes an output buffer, reads an input buffer and writes a control register. The external side sees the bus, the select lines, two strobe outputs, two passive strobe inputs, a status-read input and two buffer-state pins.

Each direction works on its own in one of two modes. In active mode the block drives a strobe low for a programmable number of clock cycles, 1 to 4. An output transfer drives the bus while its strobe is low. An input transfer captures the bus when its strobe ends. In passive mode the external device supplies the strobes, and the input-full and output-empty pins report the buffer state. An optional shadow register keeps a second incoming byte aside when the input buffer is still full, so the byte the core is working on is not overwritten. Two maskable interrupts, one per direction, report new input and a drained output buffer. The external side can read a status byte, and the core side has no path to it.

Top module: `pio_hub`

## Requirements
- R1: After reset the input buffer is empty and the output buffer is empty. The strobes `ext_ird_n` and `ext_owr_n` are high, `ext_sel` is 0, `ext_d_oe` is 0 and both interrupts are low. The control register is 0, so both directions start passive, ext_obe reads 1 and ext_ibf reads 0.
- R2: The control byte `core_ctrl_wdata` is laid out as follows:
  - bits [1:0], width code w
  - bit 2, input active
  - bit 3, output active
  - bit 4, input interrupt enable
  - bit 5, output interrupt enable
  - bit 6, shadow enable

  In output-active mode, `core_out_we` on an idle output stores the byte and the port. The next cycle `ext_owr_n` goes low and stays low for exactly w+1 cycles. Throughout that time `ext_d_oe` is 1, `ext_d_out` is the byte and `ext_sel` is the port. The output buffer is empty once the strobe returns high.
- R3: In input-active mode, `core_in_req` on an idle input latches the port. It drives `ext_ird_n` low for exactly w+1 cycles and captures `ext_d_in` into the input buffer on the last of them. The captured byte is on `core_in_data` and the buffer is full when the strobe returns high.
- R4: In input-passive mode, the clock edge at which `ext_in_stb` is first seen high loads `ext_d_in` into the input buffer. From then on ext_ibf is 1.
- R5: In output-passive mode, a core write clears ext_obe to 0. While `ext_out_stb` is high, `ext_d_oe` is 1 and `ext_d_out` shows the buffered byte. The edge at which `ext_out_stb` is first seen high sets ext_obe back to 1.
- R6: While `ext_stat_rd` is high, `ext_d_oe` is 1 and `ext_d_out` carries the status byte:
  - bit 0, input full
  - bit 1, output empty
  - bit 2, shadow full
  - bit 3, input active
  - bit 4, output active
  - bits [7:5], current select
- R7: `irq_in` is a one-cycle pulse one cycle after the input buffer goes from empty to full, provided the input interrupt enable is set. With the enable clear it stays low.
- R8: `irq_out` is a one-cycle pulse one cycle after the output buffer goes from holding data to empty, provided the output interrupt enable is set.
- R9: With shadow enable set, a byte that arrives while the input buffer is full goes to the shadow register, and `core_in_data` keeps the first byte. A `core_in_rd` then moves the shadow byte into the input buffer, which stays full. A further `core_in_rd` empties it.
- R10: With shadow enable clear, a byte that arrives while the input buffer is full replaces the buffered byte, and the shadow stays empty.
- R11: ext_ibf is forced to 0 while input is active, and ext_obe is forced to 0 while output is active. The other direction's mode does not affect either pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_ctrl_we | input | 1 | Write strobe for the control register |
| core_ctrl_wdata | input | 7 | Control byte |
| core_out_we | input | 1 | Write the output buffer |
| core_out_data | input | 8 | Byte to send |
| core_port | input | 3 | Logical port for the write or the request |
| core_in_req | input | 1 | Start an active input transfer |
| core_in_rd | input | 1 | Consume the input buffer |
| core_in_data | output | 8 | Input buffer contents |
| ext_sel | output | 3 | Logical port select |
| ext_d_in | input | 8 | External bus, inbound |
| ext_d_out | output | 8 | External bus, outbound |
| ext_d_oe | output | 1 | Outbound bus drive enable |
| ext_ird_n | output | 1 | Active-mode input strobe, low true |
| ext_owr_n | output | 1 | Active-mode output strobe, low true |
| ext_in_stb | input | 1 | Passive-mode input strobe |
| ext_out_stb | input | 1 | Passive-mode output strobe |
| ext_stat_rd | input | 1 | External status read |
| ext_ibf | output | 1 | Passive input-full pin |
| ext_obe | output | 1 | Passive output-empty pin |
| irq_in | output | 1 | Input interrupt pulse |
| irq_out | output | 1 | Output interrupt pulse |

## Verification
Active strobes go low one cycle after the request. The bench counts low samples, which must equal w+1, and checks the captured byte at the first sample after the strobe rises. Passive strobes and core writes change the buffer flags on the next edge, and the interrupts follow one edge later. The bench therefore samples the flags at the first falling edge after the stimulus and the interrupt at the second and third. The status byte and the passive output bus are combinational in ext_stat_rd and ext_out_stb. The bench checks them shortly after driving those inputs, between clock edges.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DATA_W  = 8;
  localparam int PORTS   = 8;
  localparam int SEL_W   = $clog2(PORTS);
  localparam int WCODE_W = 2;

  typedef struct packed {
    logic               shadow_en;
    logic               out_irq_en;
    logic               in_irq_en;
    logic               out_active;
    logic               in_active;
    logic [WCODE_W-1:0] wcode;
  } pio_ctrl_t;

  localparam int CTRL_W = $bits(pio_ctrl_t);

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             out_active;
    logic             in_active;
    logic             sh_full;
    logic             out_empty;
    logic             in_full;
  } pio_stat_t;
endpackage

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] wcode,
  output logic             busy,
  output logic             done
);
  localparam int MAX_LEN = 1 << CNT_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = wcode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);

  // checker state: length of the current low strobe
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_q) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R2 / R3: a strobe never lasts longer than the widest code allows
  a_r2_width_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (run_q < (CNT_W+1)'(MAX_LEN)));

  // R3: the capture cycle ends the strobe
  a_r3_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
endmodule

// File: rtl/pio_in_path.sv
module pio_in_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd,
  input  logic              shadow_en,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              sh_full
);
  logic [DATA_W-1:0] main_q, main_d, shd_q, shd_d;
  logic              full_q, full_d, shf_q, shf_d;

  always_comb begin
    main_d = main_q;
    shd_d  = shd_q;
    full_d = full_q;
    shf_d  = shf_q;
    if (rd && full_q) begin
      if (shf_q) begin
        main_d = shd_q;
        shf_d  = 1'b0;
      end else begin
        full_d = 1'b0;
      end
    end
    if (wr) begin
      if (!full_d) begin
        main_d = wr_data;
        full_d = 1'b1;
      end else if (shadow_en) begin
        shd_d = wr_data;
        shf_d = 1'b1;
      end else begin
        main_d = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      shd_q  <= '0;
      full_q <= 1'b0;
      shf_q  <= 1'b0;
    end else begin
      main_q <= main_d;
      shd_q  <= shd_d;
      full_q <= full_d;
      shf_q  <= shf_d;
    end
  end

  assign data    = main_q;
  assign full    = full_q;
  assign sh_full = shf_q;

  // R4: any accepted byte leaves the buffer full
  a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> full_q);

  // R9: the shadow only ever holds data behind a full buffer
  a_r9_shadow_behind_full: assert property (@(posedge clk) disable iff (!rst_n)
    shf_q |-> full_q);
endmodule

// File: rtl/pio_out_path.sv
module pio_out_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              drain,
  output logic [DATA_W-1:0] data,
  output logic              empty
);
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              empty_q, empty_d;

  always_comb begin
    buf_d   = buf_q;
    empty_d = empty_q;
    if (load) begin
      buf_d   = load_data;
      empty_d = 1'b0;
    end else if (drain) begin
      empty_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      empty_q <= 1'b1;
    end else begin
      buf_q   <= buf_d;
      empty_q <= empty_d;
    end
  end

  assign data  = buf_q;
  assign empty = empty_q;

  // R5: a drain with no competing load empties the buffer
  a_r5_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !load) |=> empty_q);
endmodule

// File: rtl/pio_hub.sv
module pio_hub
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_ctrl_we,
  input  logic [CTRL_W-1:0] core_ctrl_wdata,
  input  logic              core_out_we,
  input  logic [DATA_W-1:0] core_out_data,
  input  logic [SEL_W-1:0]  core_port,
  input  logic              core_in_req,
  input  logic              core_in_rd,
  output logic [DATA_W-1:0] core_in_data,
  output logic [SEL_W-1:0]  ext_sel,
  input  logic [DATA_W-1:0] ext_d_in,
  output logic [DATA_W-1:0] ext_d_out,
  output logic              ext_d_oe,
  output logic              ext_ird_n,
  output logic              ext_owr_n,
  input  logic              ext_in_stb,
  input  logic              ext_out_stb,
  input  logic              ext_stat_rd,
  output logic              ext_ibf,
  output logic              ext_obe,
  output logic              irq_in,
  output logic              irq_out
);
  pio_ctrl_t        ctrl_q, ctrl_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             in_stb_q, out_stb_q;
  logic             in_full_q, out_empty_q;
  logic             irq_in_q, irq_in_d, irq_out_q, irq_out_d;

  logic in_busy, in_done, out_busy, out_done;
  logic in_start, out_start, out_load;
  logic in_wr, out_drain;
  logic in_full_w, sh_full_w, out_empty_w;
  logic [DATA_W-1:0] out_buf_w;
  pio_stat_t stat_w;

  // request decode
  assign out_load  = core_out_we && !(ctrl_q.out_active && out_busy);
  assign out_start = out_load && ctrl_q.out_active;
  assign in_start  = core_in_req && ctrl_q.in_active && !in_busy;

  assign in_wr = ctrl_q.in_active ? in_done
                                  : (ext_in_stb && !in_stb_q);
  assign out_drain = ctrl_q.out_active ? out_done
                                       : (ext_out_stb && !out_stb_q);

  always_comb begin
    ctrl_d = ctrl_q;
    sel_d  = sel_q;
    if (core_ctrl_we)         ctrl_d = pio_ctrl_t'(core_ctrl_wdata);
    if (out_load || in_start) sel_d  = core_port;
    irq_in_d  = ctrl_q.in_irq_en  && in_full_w   && !in_full_q;
    irq_out_d = ctrl_q.out_irq_en && out_empty_w && !out_empty_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      sel_q       <= '0;
      in_stb_q    <= 1'b0;
      out_stb_q   <= 1'b0;
      in_full_q   <= 1'b0;
      out_empty_q <= 1'b1;
      irq_in_q    <= 1'b0;
      irq_out_q   <= 1'b0;
    end else begin
      ctrl_q      <= ctrl_d;
      sel_q       <= sel_d;
      in_stb_q    <= ext_in_stb;
      out_stb_q   <= ext_out_stb;
      in_full_q   <= in_full_w;
      out_empty_q <= out_empty_w;
      irq_in_q    <= irq_in_d;
      irq_out_q   <= irq_out_d;
    end
  end

  pio_strobe_gen #(.CNT_W(WCODE_W)) u_in_stb (
    .clk(clk), .rst_n(rst_n), .start(in_start), .wcode(ctrl_q.wcode),
    .busy(in_busy), .done(in_done)
  );

  pio_strobe_gen #(.CNT_W(WCODE_W)) u_out_stb (
    .clk(clk), .rst_n(rst_n), .start(out_start), .wcode(ctrl_q.wcode),
    .busy(out_busy), .done(out_done)
  );

  pio_in_path #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n), .wr(in_wr), .wr_data(ext_d_in),
    .rd(core_in_rd), .shadow_en(ctrl_q.shadow_en),
    .data(core_in_data), .full(in_full_w), .sh_full(sh_full_w)
  );

  pio_out_path #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(out_load), .load_data(core_out_data),
    .drain(out_drain), .data(out_buf_w), .empty(out_empty_w)
  );

  always_comb begin
    stat_w.sel        = sel_q;
    stat_w.out_active = ctrl_q.out_active;
    stat_w.in_active  = ctrl_q.in_active;
    stat_w.sh_full    = sh_full_w;
    stat_w.out_empty  = out_empty_w;
    stat_w.in_full    = in_full_w;
  end

  assign ext_sel   = sel_q;
  assign ext_d_out = ext_stat_rd ? DATA_W'(stat_w) : out_buf_w;
  assign ext_d_oe  = ext_stat_rd || out_busy ||
                     (ext_out_stb && !ctrl_q.out_active);
  assign ext_ird_n = !in_busy;
  assign ext_owr_n = !out_busy;
  assign ext_ibf   = in_full_w   && !ctrl_q.in_active;
  assign ext_obe   = out_empty_w && !ctrl_q.out_active;
  assign irq_in    = irq_in_q;
  assign irq_out   = irq_out_q;

  // R7: an input interrupt lasts one cycle and follows a full buffer
  a_r7_irq_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in_q |=> !irq_in_q);
  a_r7_irq_in_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in_q |-> $past(in_full_w));

  // R8: an output interrupt follows an empty buffer
  a_r8_irq_out_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out_q |-> $past(out_empty_w));

  // R2: the select lines hold still while an output strobe is low
  a_r2_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_busy && !out_done && !in_start) |=> $stable(sel_q));
endmodule

// File: tb/pio_hub_test.sv
`timescale 1ns/1ps
module pio_hub_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       core_ctrl_we;
  logic [6:0] core_ctrl_wdata;
  logic       core_out_we;
  logic [7:0] core_out_data;
  logic [2:0] core_port;
  logic       core_in_req, core_in_rd;
  logic [7:0] core_in_data;
  logic [2:0] ext_sel;
  logic [7:0] ext_d_in, ext_d_out;
  logic       ext_d_oe, ext_ird_n, ext_owr_n;
  logic       ext_in_stb, ext_out_stb, ext_stat_rd;
  logic       ext_ibf, ext_obe, irq_in, irq_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pio_hub uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [6:0] v);
    tick(); core_ctrl_we = 1'b1; core_ctrl_wdata = v;
    tick(); core_ctrl_we = 1'b0;
  endtask

  function automatic logic [7:0] read_status_now();
    return ext_d_out;
  endfunction

  task automatic status(output logic [7:0] s);
    ext_stat_rd = 1'b1; #1; s = ext_d_out;
    ext_stat_rd = 1'b0; #0.1;
  endtask

  task automatic pulse_in(logic [7:0] d);
    tick(); ext_d_in = d; ext_in_stb = 1'b1;
    tick(); ext_in_stb = 1'b0;
  endtask

  task automatic core_read();
    tick(); core_in_rd = 1'b1;
    tick(); core_in_rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ibf", ext_ibf, 0);
    check("R1 obe", ext_obe, 1);
    check("R1 strobes", {ext_ird_n, ext_owr_n}, 2'b11);
    check("R1 sel", ext_sel, 0);
    check("R1 oe", ext_d_oe, 0);
    check("R1 irqs", {irq_in, irq_out}, 0);
  endtask

  task automatic t_active_out(logic [1:0] w, logic [2:0] port, logic [7:0] d);
    int lows;
    logic [7:0] s;
    wr_ctrl({4'b0001, 1'b0, w});
    tick(); core_out_we = 1'b1; core_out_data = d; core_port = port;
    tick(); core_out_we = 1'b0;
    check("R2 data", ext_d_out, d);
    check("R2 oe", ext_d_oe, 1);
    check("R2 sel", ext_sel, port);
    check("R11 obe forced low", ext_obe, 0);
    lows = 0;
    while (ext_owr_n == 1'b0 && lows < 10) begin lows++; tick(); end
    check("R2 width", lows, w + 1);
    status(s);
    check("R2 empty after strobe", s[1], 1);
    check("R6 out active bit", s[4], 1);
    check("R11 obe still low", ext_obe, 0);
  endtask

  task automatic t_active_in(logic [1:0] w, logic [2:0] port, logic [7:0] d);
    int lows;
    logic [7:0] s;
    wr_ctrl({4'b0000, 1'b1, w});
    ext_d_in = d;
    tick(); core_in_req = 1'b1; core_port = port;
    tick(); core_in_req = 1'b0;
    check("R3 sel", ext_sel, port);
    lows = 0;
    while (ext_ird_n == 1'b0 && lows < 10) begin lows++; tick(); end
    check("R3 width", lows, w + 1);
    check("R3 data", core_in_data, d);
    status(s);
    check("R3 full", s[0], 1);
    check("R6 in active bit and sel", {s[7:5], s[3]}, {port, 1'b1});
    check("R11 ibf forced low", ext_ibf, 0);
    core_read();
  endtask

  task automatic t_passive_in(bit en);
    wr_ctrl(en ? 7'h10 : 7'h00);
    tick(); ext_d_in = 8'hC3; ext_in_stb = 1'b1;
    tick();
    check("R4 ibf", ext_ibf, 1);
    check("R4 data", core_in_data, 8'hC3);
    check(en ? "R7 irq not yet" : "R7 masked a", irq_in, 0);
    tick(); ext_in_stb = 1'b0;
    check(en ? "R7 irq pulse" : "R7 masked b", irq_in, en);
    tick();
    check("R7 irq ends", irq_in, 0);
    core_read();
    check("R4 ibf clears on read", ext_ibf, 0);
  endtask

  task automatic t_passive_out();
    logic [7:0] s;
    wr_ctrl(7'h20);
    tick(); core_out_we = 1'b1; core_out_data = 8'h5A; core_port = 3'd6;
    tick(); core_out_we = 1'b0;
    check("R5 obe low", ext_obe, 0);
    check("R8 no irq on load", irq_out, 0);
    ext_out_stb = 1'b1; #1;
    check("R5 bus", {ext_d_oe, ext_d_out}, {1'b1, 8'h5A});
    status(s);
    check("R6 status byte", s, {3'd6, 5'b00000});
    tick();
    check("R5 obe high", ext_obe, 1);
    tick(); ext_out_stb = 1'b0;
    check("R8 irq pulse", irq_out, 1);
    tick();
    check("R8 irq ends", irq_out, 0);
    check("R5 oe off", ext_d_oe, 0);
  endtask

  task automatic t_shadow();
    logic [7:0] s;
    wr_ctrl(7'h40);
    pulse_in(8'h11);
    pulse_in(8'h22);
    tick();
    check("R9 keeps first", core_in_data, 8'h11);
    status(s);
    check("R9 shadow full", s[2:0], 3'b111);
    core_read();
    check("R9 shadow moved", core_in_data, 8'h22);
    status(s);
    check("R9 still full", s[2:0], 3'b011);
    core_read();
    check("R9 empty", ext_ibf, 0);
  endtask

  task automatic t_overwrite();
    logic [7:0] s;
    wr_ctrl(7'h00);
    pulse_in(8'h33);
    pulse_in(8'h44);
    tick();
    check("R10 replaced", core_in_data, 8'h44);
    status(s);
    check("R10 no shadow", s[2:0], 3'b011);
    core_read();
  endtask

  task automatic t_mixed_modes();
    wr_ctrl(7'h04);
    pulse_in(8'h55);
    tick();
    check("R11 ibf with output only passive", ext_ibf, 0);
    check("R11 obe with output passive", ext_obe, 1);
    core_read();
    wr_ctrl(7'h08);
    pulse_in(8'h66);
    tick();
    check("R11 ibf with input passive", ext_ibf, 1);
    check("R11 obe with output active", ext_obe, 0);
    core_read();
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    core_ctrl_we = 0; core_ctrl_wdata = 0; core_out_we = 0; core_out_data = 0;
    core_port = 0; core_in_req = 0; core_in_rd = 0; ext_d_in = 0;
    ext_in_stb = 0; ext_out_stb = 0; ext_stat_rd = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_active_out(2'd0, 3'd1, 8'hA1);
    t_active_out(2'd3, 3'd7, 8'h3C);
    t_active_in(2'd1, 3'd4, 8'h96);
    t_active_in(2'd2, 3'd2, 8'h0F);
    t_passive_in(1'b1);
    t_passive_in(1'b0);
    t_passive_out();
    t_shadow();
    t_overwrite();
    t_mixed_modes();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule